// File: doc/BRIEF.md
# Erase, Program and Verify Sequencer for Many-Time-Programmable Flash

This block runs a complete burn cycle on an external byte-wide electrically erasable part. After one start command it applies a timed chip-wide erase pulse with both supervoltage enables raised. It then reads every location of the part and requires each one to be all-ones. Next it programs image bytes from address zero up to a caller-supplied last address, one timed strobe pulse per byte. Finally it reads that range back and compares each byte against the image. The block only switches logic-level enables for the high-voltage drivers. It does not generate or regulate the voltages.

Image bytes come from a small host-side buffer through a request/valid stream. The stream is walked twice in address order: once while programming and once while verifying. Every pulse, setup, hold, recovery and read-access interval is a parameter counted in clock cycles. The sequencer stops at the first byte that reads back wrong and reports that address. Otherwise it reports success. In both cases it ends idle with every enable inactive.

Top module: `mtp_burn_seq`

## Requirements
- R1: Out of reset and whenever `busy_o` is low: chip enable, read enable and strobe are high (inactive), both supervoltage enables are low, data drive is off and no image byte is requested.
- R2: The erase strobe is low for exactly ERASE_CYC cycles. For the whole pulse, both supervoltage enables are high, chip enable is low and read enable is high. Exactly one erase pulse occurs per run.
- R3: After the erase strobe, both supervoltage enables are low at least RECOV_CYC cycles before read enable first goes low. Read enable is never low while either supervoltage enable is high.
- R4: Erase verify reads every address from 0 to 2^AW-1, including addresses above the last address. At the first byte that is not all-ones, the run ends with fail at that address and no program strobe is issued.
- R5: `img_req_o` stays high until `img_valid_i` is sampled high. Each valid cycle consumes one byte. The stream is consumed for addresses 0..last in order, once to program and once to verify.
- R6: Each program strobe is low for exactly PROG_CYC cycles. During it the supply enable is high, the address-line enable is low, chip enable is low, read enable is high and data is driven with the image byte for the presented address. The pulses go to addresses 0..last, ascending, one each.
- R7: Address, write data and chip enable do not change for at least SETUP_CYC cycles before any strobe falls, nor for at least SETUP_CYC cycles after it rises.
- R8: The supply enable is low before the read-back. At the first address whose read value differs from the image byte, the run ends with fail at that address.
- R9: `done_o` is high for one cycle at the end of each run, then the block is idle. `pass_o` and `fail_addr_o` are valid in that cycle and hold until the next start. A passing run reports `fail_addr_o` = 0.
- R10: `busy_o` is high from the cycle after an accepted start through the `done_o` cycle. A start received while busy has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start command, sampled while idle |
| last_addr_i | input | AW | Highest address to program, captured at start |
| img_data_i | input | DW | Image byte from the host buffer |
| img_valid_i | input | 1 | Image byte valid; consumes one byte |
| img_req_o | output | 1 | Request for the next image byte |
| mem_addr_o | output | AW | Address to the part |
| mem_wdata_o | output | DW | Data to the part |
| mem_wdata_oe_o | output | 1 | Drive enable for the data lines |
| mem_rdata_i | input | DW | Data read from the part |
| chip_en_n_o | output | 1 | Chip enable, active low |
| rd_en_n_o | output | 1 | Output/read enable, active low |
| strobe_n_o | output | 1 | Program/erase strobe, active low |
| hv_addr_o | output | 1 | Supervoltage enable for the erase-select address line |
| hv_supply_o | output | 1 | Enable for the high programming supply |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle end-of-run flag |
| pass_o | output | 1 | Result of the last run |
| fail_addr_o | output | AW | First failing address of the last run |

## Verification
The hardest cases to reach from the ports are the two failure paths. A freshly erased part never reads anything but all-ones, and a programmed part reads back exactly what was written. The bench therefore wraps the sequencer in a behavioural part model with two injectable faults. The first is a bit stuck at zero, which defeats the erase verify even at addresses above the last programmed one. The second is a bit stuck at one, which can only show up in the read-back when the image byte has that bit clear. The pulse-edge monitors then measure strobe width, setup, hold and recovery windows in cycles for every pulse of a sweep over all last-address values.

// File: rtl/burn_pkg.sv
package burn_pkg;

   typedef enum logic [4:0] {
      ST_IDLE,
      ST_ER_HV,
      ST_ER_CE,
      ST_ER_PULSE,
      ST_ER_HOLD,
      ST_ER_RECOV,
      ST_ER_READ,
      ST_PG_SUPPLY,
      ST_PG_FETCH,
      ST_PG_SETUP,
      ST_PG_PULSE,
      ST_PG_HOLD,
      ST_PG_OFF,
      ST_VF_FETCH,
      ST_VF_READ,
      ST_DONE
   } burn_state_e;

   function automatic int unsigned cyc_max(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/burn_timer.sv
module burn_timer #(
   parameter int unsigned TW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic [TW-1:0] len_i,
   output logic          expired_o
);

   logic [TW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load_i)
         cnt_q <= len_i;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/burn_addr_ctr.sv
module burn_addr_ctr #(
   parameter int unsigned AW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr_i,
   input  logic          inc_i,
   input  logic [AW-1:0] last_i,
   output logic [AW-1:0] addr_o,
   output logic          at_last_o,
   output logic          at_top_o
);

   logic [AW-1:0] addr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         addr_q <= '0;
      else if (clr_i)
         addr_q <= '0;
      else if (inc_i)
         addr_q <= addr_q + 1'b1;
   end

   assign addr_o    = addr_q;
   assign at_last_o = (addr_q == last_i);
   assign at_top_o  = &addr_q;

endmodule

// File: rtl/mtp_burn_seq.sv
module mtp_burn_seq
   import burn_pkg::*;
#(
   parameter int unsigned AW        = 18,
   parameter int unsigned DW        = 8,
   parameter int unsigned SETUP_CYC = 50,
   parameter int unsigned PROG_CYC  = 750,
   parameter int unsigned ERASE_CYC = 5000000,
   parameter int unsigned RECOV_CYC = 50,
   parameter int unsigned ACC_CYC   = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic [AW-1:0] last_addr_i,
   input  logic [DW-1:0] img_data_i,
   input  logic          img_valid_i,
   output logic          img_req_o,
   output logic [AW-1:0] mem_addr_o,
   output logic [DW-1:0] mem_wdata_o,
   output logic          mem_wdata_oe_o,
   input  logic [DW-1:0] mem_rdata_i,
   output logic          chip_en_n_o,
   output logic          rd_en_n_o,
   output logic          strobe_n_o,
   output logic          hv_addr_o,
   output logic          hv_supply_o,
   output logic          busy_o,
   output logic          done_o,
   output logic          pass_o,
   output logic [AW-1:0] fail_addr_o
);

   localparam int unsigned T_MAX =
      cyc_max(cyc_max(cyc_max(SETUP_CYC, PROG_CYC), cyc_max(ERASE_CYC, RECOV_CYC)), ACC_CYC);
   localparam int unsigned TW = (T_MAX > 1) ? $clog2(T_MAX) : 1;
   localparam logic [TW-1:0] L_SETUP = TW'(SETUP_CYC - 1);
   localparam logic [TW-1:0] L_PROG  = TW'(PROG_CYC - 1);
   localparam logic [TW-1:0] L_ERASE = TW'(ERASE_CYC - 1);
   localparam logic [TW-1:0] L_RECOV = TW'(RECOV_CYC - 1);
   localparam logic [TW-1:0] L_ACC   = TW'(ACC_CYC - 1);
   localparam logic [DW-1:0] BLANK   = {DW{1'b1}};

   generate
      if (AW < 1 || DW < 1) begin : g_bad_width
         $error("mtp_burn_seq: AW and DW must be at least 1");
      end
      if (SETUP_CYC < 1 || PROG_CYC < 1 || ERASE_CYC < 1 || RECOV_CYC < 1 || ACC_CYC < 1) begin : g_bad_time
         $error("mtp_burn_seq: every cycle count must be at least 1");
      end
   endgenerate

   burn_state_e   st_q, st_d;
   logic          tmr_ld, tmr_exp;
   logic [TW-1:0] tmr_len;
   logic          a_clr, a_inc, a_last, a_top;
   logic [AW-1:0] addr;
   logic [AW-1:0] last_q;
   logic [DW-1:0] byte_q;
   logic          byte_ld, end_pass, end_fail, accept;
   logic          pass_q;
   logic [AW-1:0] fail_q;

   burn_timer #(.TW(TW)) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_i    (tmr_ld),
      .len_i     (tmr_len),
      .expired_o (tmr_exp)
   );

   burn_addr_ctr #(.AW(AW)) u_addr (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr_i     (a_clr),
      .inc_i     (a_inc),
      .last_i    (last_q),
      .addr_o    (addr),
      .at_last_o (a_last),
      .at_top_o  (a_top)
   );

   assign accept = (st_q == ST_IDLE) && start_i;

   always_comb begin
      st_d     = st_q;
      tmr_ld   = 1'b0;
      tmr_len  = '0;
      a_clr    = 1'b0;
      a_inc    = 1'b0;
      byte_ld  = 1'b0;
      end_pass = 1'b0;
      end_fail = 1'b0;
      unique case (st_q)
         ST_IDLE: if (start_i) begin
            st_d = ST_ER_HV; tmr_ld = 1'b1; tmr_len = L_SETUP; a_clr = 1'b1;
         end
         ST_ER_HV: if (tmr_exp) begin
            st_d = ST_ER_CE; tmr_ld = 1'b1; tmr_len = L_SETUP;
         end
         ST_ER_CE: if (tmr_exp) begin
            st_d = ST_ER_PULSE; tmr_ld = 1'b1; tmr_len = L_ERASE;
         end
         ST_ER_PULSE: if (tmr_exp) begin
            st_d = ST_ER_HOLD; tmr_ld = 1'b1; tmr_len = L_SETUP;
         end
         ST_ER_HOLD: if (tmr_exp) begin
            st_d = ST_ER_RECOV; tmr_ld = 1'b1; tmr_len = L_RECOV; a_clr = 1'b1;
         end
         ST_ER_RECOV: if (tmr_exp) begin
            st_d = ST_ER_READ; tmr_ld = 1'b1; tmr_len = L_ACC;
         end
         ST_ER_READ: if (tmr_exp) begin
            if (mem_rdata_i != BLANK) begin
               st_d = ST_DONE; end_fail = 1'b1;
            end else if (a_top) begin
               st_d = ST_PG_SUPPLY; tmr_ld = 1'b1; tmr_len = L_SETUP; a_clr = 1'b1;
            end else begin
               a_inc = 1'b1; tmr_ld = 1'b1; tmr_len = L_ACC;
            end
         end
         ST_PG_SUPPLY: if (tmr_exp) st_d = ST_PG_FETCH;
         ST_PG_FETCH: if (img_valid_i) begin
            st_d = ST_PG_SETUP; byte_ld = 1'b1; tmr_ld = 1'b1; tmr_len = L_SETUP;
         end
         ST_PG_SETUP: if (tmr_exp) begin
            st_d = ST_PG_PULSE; tmr_ld = 1'b1; tmr_len = L_PROG;
         end
         ST_PG_PULSE: if (tmr_exp) begin
            st_d = ST_PG_HOLD; tmr_ld = 1'b1; tmr_len = L_SETUP;
         end
         ST_PG_HOLD: if (tmr_exp) begin
            if (a_last) begin
               st_d = ST_PG_OFF; tmr_ld = 1'b1; tmr_len = L_SETUP; a_clr = 1'b1;
            end else begin
               st_d = ST_PG_FETCH; a_inc = 1'b1;
            end
         end
         ST_PG_OFF: if (tmr_exp) st_d = ST_VF_FETCH;
         ST_VF_FETCH: if (img_valid_i) begin
            st_d = ST_VF_READ; byte_ld = 1'b1; tmr_ld = 1'b1; tmr_len = L_ACC;
         end
         ST_VF_READ: if (tmr_exp) begin
            if (mem_rdata_i != byte_q) begin
               st_d = ST_DONE; end_fail = 1'b1;
            end else if (a_last) begin
               st_d = ST_DONE; end_pass = 1'b1;
            end else begin
               st_d = ST_VF_FETCH; a_inc = 1'b1;
            end
         end
         ST_DONE: st_d = ST_IDLE;
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         last_q <= '0;
         byte_q <= '0;
         pass_q <= 1'b0;
         fail_q <= '0;
      end else begin
         st_q <= st_d;
         if (accept) begin
            last_q <= last_addr_i;
            pass_q <= 1'b0;
            fail_q <= '0;
         end
         if (byte_ld)
            byte_q <= img_data_i;
         if (end_pass)
            pass_q <= 1'b1;
         if (end_fail)
            fail_q <= addr;
      end
   end

   // Pin decode: each state owns one fixed pin pattern.
   always_comb begin
      chip_en_n_o    = 1'b1;
      rd_en_n_o      = 1'b1;
      strobe_n_o     = 1'b1;
      hv_addr_o      = 1'b0;
      hv_supply_o    = 1'b0;
      mem_wdata_oe_o = 1'b0;
      img_req_o      = 1'b0;
      unique case (st_q)
         ST_ER_HV: begin
            hv_addr_o = 1'b1; hv_supply_o = 1'b1;
         end
         ST_ER_CE, ST_ER_HOLD: begin
            hv_addr_o = 1'b1; hv_supply_o = 1'b1; chip_en_n_o = 1'b0;
         end
         ST_ER_PULSE: begin
            hv_addr_o = 1'b1; hv_supply_o = 1'b1; chip_en_n_o = 1'b0; strobe_n_o = 1'b0;
         end
         ST_ER_READ, ST_VF_READ: begin
            chip_en_n_o = 1'b0; rd_en_n_o = 1'b0;
         end
         ST_PG_SUPPLY:
            hv_supply_o = 1'b1;
         ST_PG_FETCH: begin
            hv_supply_o = 1'b1; chip_en_n_o = 1'b0; img_req_o = 1'b1;
         end
         ST_PG_SETUP, ST_PG_HOLD: begin
            hv_supply_o = 1'b1; chip_en_n_o = 1'b0; mem_wdata_oe_o = 1'b1;
         end
         ST_PG_PULSE: begin
            hv_supply_o = 1'b1; chip_en_n_o = 1'b0; mem_wdata_oe_o = 1'b1; strobe_n_o = 1'b0;
         end
         ST_VF_FETCH:
            img_req_o = 1'b1;
         default: ;
      endcase
   end

   assign mem_addr_o  = addr;
   assign mem_wdata_o = byte_q;
   assign busy_o      = (st_q != ST_IDLE);
   assign done_o      = (st_q == ST_DONE);
   assign pass_o      = pass_q;
   assign fail_addr_o = fail_q;

   // R1: idle means every enable inactive
   assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> (chip_en_n_o && rd_en_n_o && strobe_n_o && !hv_addr_o && !hv_supply_o
                   && !mem_wdata_oe_o && !img_req_o));

   // R2 and R6: a strobe only starts with the supply on, chip enabled and reads off
   assert_strobe_cond_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(strobe_n_o) |-> (hv_supply_o && !chip_en_n_o && rd_en_n_o));

   // R3: no read while any supervoltage enable is raised
   assert_read_lowv_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en_n_o |-> (!hv_addr_o && !hv_supply_o));

   // R5: a pending image request is held until it is served
   assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (img_req_o && !img_valid_i) |=> img_req_o);

   // R7: address, data and chip enable frozen while the strobe is low
   assert_pulse_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!strobe_n_o && $past(!strobe_n_o)) |->
         ($stable(mem_addr_o) && $stable(mem_wdata_o) && $stable(chip_en_n_o)));

   // R9: the end flag is followed by idle
   assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !busy_o);

   // R10: busy cannot drop before the end flag
   assert_busy_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !done_o) |=> busy_o);

endmodule

// File: tb/mtp_burn_seq_test.sv
module mtp_burn_seq_test;

   localparam int CLK_PERIOD = 10;
   localparam int AW = 4;
   localparam int DW = 8;
   localparam int NB = 16;
   localparam int SETUP = 3;
   localparam int PROG = 6;
   localparam int ERASE = 20;
   localparam int RECOV = 4;
   localparam int ACC = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic [AW-1:0] last_addr = '0;
   logic [DW-1:0] img_data = '0;
   logic img_valid = 1'b0;
   logic img_req, wdata_oe, chip_en_n, rd_en_n, strobe_n, hv_addr, hv_supply;
   logic busy, done, pass;
   logic [AW-1:0] mem_addr, fail_addr;
   logic [DW-1:0] wdata, rdata;

   always #(CLK_PERIOD/2) clk = ~clk;

   mtp_burn_seq #(.AW(AW), .DW(DW), .SETUP_CYC(SETUP), .PROG_CYC(PROG),
                  .ERASE_CYC(ERASE), .RECOV_CYC(RECOV), .ACC_CYC(ACC)) uut (
      .clk(clk), .rst_n(rst_n), .start_i(start), .last_addr_i(last_addr),
      .img_data_i(img_data), .img_valid_i(img_valid), .img_req_o(img_req),
      .mem_addr_o(mem_addr), .mem_wdata_o(wdata), .mem_wdata_oe_o(wdata_oe),
      .mem_rdata_i(rdata), .chip_en_n_o(chip_en_n), .rd_en_n_o(rd_en_n),
      .strobe_n_o(strobe_n), .hv_addr_o(hv_addr), .hv_supply_o(hv_supply),
      .busy_o(busy), .done_o(done), .pass_o(pass), .fail_addr_o(fail_addr));

   // part model and fault settings
   logic [DW-1:0] mem [NB];
   logic [DW-1:0] img [NB];
   logic s0_en = 1'b0, s1_en = 1'b0;
   logic [AW-1:0] s0_addr = '0, s1_addr = '0;
   wire [DW-1:0] m0 = (s0_en && mem_addr == s0_addr) ? 8'h08 : 8'h00;
   wire [DW-1:0] m1 = (s1_en && mem_addr == s1_addr) ? 8'h04 : 8'h00;
   assign rdata = (!chip_en_n && !rd_en_n) ? ((mem[mem_addr] & ~m0) | m1) : 8'h00;

   int vectors = 0, miscompares = 0;

   // monitor counters
   int n_erase, n_prog, n_stream, ptr;
   int bad_ew, bad_pw, bad_econd, bad_pcond, bad_order, bad_pdata;
   int bad_setup, bad_hold, bad_rec, bad_rdhv;
   int st_cnt, h_cnt, r_cnt, pw;
   bit hold_act, rec_act, kind_erase;
   logic p_strobe, p_hva, p_busy, p_ce;
   logic [AW-1:0] p_addr;
   logic [DW-1:0] p_wdata;

   always @(negedge clk) begin
      if (!rst_n) begin
         p_strobe = 1; p_hva = 0; p_busy = 0; p_ce = 1; p_addr = '0; p_wdata = '0;
         hold_act = 0; rec_act = 0; st_cnt = 0; img_valid = 0; ptr = 0;
      end else begin
         if (!p_busy && busy) begin
            n_erase = 0; n_prog = 0; n_stream = 0; ptr = 0;
            bad_ew = 0; bad_pw = 0; bad_econd = 0; bad_pcond = 0; bad_order = 0;
            bad_pdata = 0; bad_setup = 0; bad_hold = 0; bad_rec = 0; bad_rdhv = 0;
            hold_act = 0; rec_act = 0;
            for (int i = 0; i < NB; i++) mem[i] = 8'h5A ^ 8'(i * 13);
         end
         // image stream source
         if (img_valid) img_valid = 0;
         else if (img_req) begin
            img_valid = 1; img_data = img[ptr];
            ptr = (ptr == int'(last_addr)) ? 0 : ptr + 1;
            n_stream++;
         end
         if ((mem_addr != p_addr) || (wdata != p_wdata) || (chip_en_n != p_ce)) begin
            if (hold_act) begin
               if (h_cnt < SETUP) bad_hold++;
               hold_act = 0;
            end
            st_cnt = 0;
         end else begin
            st_cnt++;
            if (hold_act) h_cnt++;
         end
         if (!p_strobe && strobe_n) begin
            if (kind_erase) begin if (pw != ERASE) bad_ew++; end
            else if (pw != PROG) bad_pw++;
            hold_act = 1; h_cnt = 1;
         end
         if (p_strobe && !strobe_n) begin
            if (st_cnt < SETUP) bad_setup++;
            pw = 0;
            if (hv_addr) begin
               kind_erase = 1; n_erase++;
               if (!(hv_supply && !chip_en_n && rd_en_n)) bad_econd++;
               for (int i = 0; i < NB; i++) mem[i] = 8'hFF;
            end else begin
               kind_erase = 0;
               if (!(hv_supply && !chip_en_n && rd_en_n && wdata_oe)) bad_pcond++;
               if (int'(mem_addr) != n_prog) bad_order++;
               if (wdata != img[mem_addr]) bad_pdata++;
               mem[mem_addr] = mem[mem_addr] & wdata;
               n_prog++;
            end
         end
         if (!strobe_n) pw++;
         if (rec_act && !rd_en_n) begin
            if (r_cnt < RECOV) bad_rec++;
            rec_act = 0;
         end else if (rec_act) r_cnt++;
         if (p_hva && !hv_addr) begin rec_act = 1; r_cnt = 1; end
         if (!rd_en_n && (hv_addr || hv_supply)) bad_rdhv++;
         p_strobe = strobe_n; p_hva = hv_addr; p_busy = busy; p_ce = chip_en_n;
         p_addr = mem_addr; p_wdata = wdata;
      end
   end

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      vectors++;
      if (!ok) begin
         miscompares++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic check_quiet(input string req);
      check(!busy && chip_en_n && rd_en_n && strobe_n && !hv_addr && !hv_supply
            && !wdata_oe && !img_req, req, "idle pins",
            {busy, chip_en_n, rd_en_n, strobe_n, hv_addr, hv_supply, wdata_oe, img_req},
            8'b0111_0000);
   endtask

   // One complete run. kind: 0 pass, 1 erase fault, 2 program fault
   task automatic run(input int last, input int kind, input int fault_at, input bit poke);
      int exp_stream;
      int bad_mem;
      last_addr = AW'(last);
      @(negedge clk); start = 1;
      @(negedge clk); start = 0;
      check(busy, "R10", "busy after start", busy, 1);
      if (poke) begin
         repeat (10) @(negedge clk);
         start = 1; @(negedge clk); start = 0;
      end
      while (!done) @(negedge clk);
      if (kind == 0) begin
         check(pass, "R9", "pass flag", pass, 1);
         check(fail_addr == 0, "R9", "fail addr on pass", fail_addr, 0);
      end else begin
         check(!pass, kind == 1 ? "R4" : "R8", "fail flag", pass, 0);
         check(int'(fail_addr) == fault_at, kind == 1 ? "R4" : "R8", "fail addr",
               fail_addr, fault_at);
      end
      @(negedge clk);
      check_quiet("R1");
      repeat (3) @(negedge clk);
      check(pass == (kind == 0) && (kind == 0 || int'(fail_addr) == fault_at), "R9",
            "result held", pass, kind == 0);
      check(n_erase == 1 && bad_ew == 0 && bad_econd == 0, "R2", "erase pulses/width/cond",
            n_erase * 100 + bad_ew + bad_econd, 100);
      check(bad_rec == 0 && bad_rdhv == 0, "R3", "recovery/read-hv", bad_rec + bad_rdhv, 0);
      check(bad_setup == 0 && bad_hold == 0, "R7", "setup/hold", bad_setup * 100 + bad_hold, 0);
      if (kind == 1) begin
         check(n_prog == 0, "R4", "no program after erase fault", n_prog, 0);
         check(n_stream == 0, "R5", "no image bytes taken", n_stream, 0);
      end else begin
         check(n_prog == last + 1 && bad_pw == 0 && bad_pcond == 0 && bad_order == 0
               && bad_pdata == 0, "R6", "program pulses", n_prog, last + 1);
         exp_stream = (kind == 0) ? 2 * (last + 1) : last + 1 + fault_at + 1;
         check(n_stream == exp_stream, "R5", "image bytes taken", n_stream, exp_stream);
         bad_mem = 0;
         for (int a = 0; a < NB; a++)
            if (mem[a] != ((a <= last) ? img[a] : 8'hFF)) bad_mem++;
         check(bad_mem == 0, "R6", "part contents", bad_mem, 0);
      end
      if (poke) begin
         repeat (5) @(negedge clk);
         check(!busy, "R10", "start while busy ignored", busy, 0);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      miscompares++;
      $display("FAIL watchdog: actual timeout expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      for (int a = 0; a < NB; a++) img[a] = 8'h00;
      repeat (3) @(negedge clk);
      check_quiet("R1");
      rst_n = 1;
      repeat (2) @(negedge clk);
      check_quiet("R1");
      // sweep every last address with a distinct pattern (R6, R5)
      for (int l = 0; l < NB; l++) begin
         for (int a = 0; a < NB; a++) img[a] = 8'(a * 29 + l * 7 + 3);
         run(l, 0, 0, 0);
      end
      // all-zero and all-one images
      for (int a = 0; a < NB; a++) img[a] = 8'h00;
      run(NB - 1, 0, 0, 0);
      for (int a = 0; a < NB; a++) img[a] = 8'hFF;
      run(NB - 1, 0, 0, 0);
      // R4: erase fault above the programmed range, and at address zero
      for (int a = 0; a < NB; a++) img[a] = 8'(a * 3 + 1);
      s0_en = 1; s0_addr = 4'd9;
      run(3, 1, 9, 0);
      s0_addr = 4'd0;
      run(15, 1, 0, 0);
      s0_en = 0;
      // R8: stuck-one bit where the image clears it
      for (int a = 0; a < NB; a++) img[a] = 8'(a * 3 + 1) & 8'hFB;
      s1_en = 1; s1_addr = 4'd3;
      run(15, 2, 3, 0);
      // stuck-one beyond the last address is never compared
      s1_addr = 4'd12;
      run(5, 0, 0, 0);
      s1_en = 0;
      // R10: start pulse in the middle of a run
      run(7, 0, 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule